// File: doc/BRIEF.md
# Shared-Control Storage Bank

This block groups eight single-bit storage cells that all use one clock, one clock enable and one set/reset. Four of the cells are dual-mode. A single build-time switch makes all four of them edge-triggered flip-flops or all four level-sensitive latches. The other four cells are always edge-triggered.

Each cell has its own build-time constant. This constant is the value it holds after configuration, and it is also the value that set/reset forces into it. A cell can therefore be preset or cleared, but never both. Two more build-time switches apply to the whole bank. One makes set/reset act at the clock edge or at once. The other inverts the clock at the bank boundary.

Each cell has a source selector, driven at run time, that picks its data input. A dual-mode cell chooses among four sources: the wide function output, the carry output, the wide-multiplexer output and a direct bypass input. A flip-flop-only cell chooses between the narrow function output and the bypass input. When the dual-mode cells are built as latches, the flip-flop-only cells are out of service and keep their configured values.

Top module: `shared_ctl_regbank`

## Requirements
- R1: After configuration, and before any clock edge or set/reset, every output bit equals its cell's configured value (`INIT_DUAL`, `INIT_PLAIN`).
- R2: In flip-flop mode, at an effective rising edge with `ce`=1 and `sr`=0, dual-mode cell i loads the source named by `dual_sel[2i+1:2i]`: 0 wide function, 1 carry, 2 wide multiplexer, 3 bypass.
- R3: At an effective rising edge with `ce`=1 and `sr`=0, flip-flop-only cell i loads the narrow function output when `plain_sel[i]`=0 and the bypass input when it is 1.
- R4: With `ce`=0 and `sr`=0, every cell keeps its value whatever its sources do.
- R5: With `sr`=1, every cell takes its configured value, and `ce` has no effect.
- R6: With `SR_ASYNC`=0, set/reset acts only at an effective rising edge, and a pulse that falls between edges has no effect. With `SR_ASYNC`=1, the outputs take their configured values as soon as `sr` rises, with no clock edge.
- R7: With `CLK_INV`=1, the edge-triggered cells capture on the falling edge of `clk`.
- R8: With `DUAL_LATCH`=1, a dual-mode cell follows its selected source while the effective clock is high and `ce`=1, and holds when the effective clock is low or `ce`=0.
- R9: With `DUAL_LATCH`=1, `plain_q` stays at `INIT_PLAIN` whatever the data, `ce`, `sr` and clock do.
- R10: With `DUAL_LATCH`=1 and `SR_ASYNC`=1, raising `sr` while the latches are closed forces the dual-mode outputs to their configured values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock, inverted inside when `CLK_INV`=1 |
| ce | input | 1 | Shared clock enable, active high |
| sr | input | 1 | Shared set/reset, active high |
| dual_sel | input | 2*N | Source code per dual-mode cell, two bits each |
| plain_sel | input | N | Source bit per flip-flop-only cell |
| lut6_d | input | N | Wide function outputs, one per dual-mode cell |
| carry_d | input | N | Carry outputs, one per dual-mode cell |
| wmux_d | input | N | Wide multiplexer outputs, one per dual-mode cell |
| lut5_d | input | N | Narrow function outputs, one per flip-flop-only cell |
| byp_d | input | N | Bypass inputs, shared by cell index across both groups |
| dual_q | output | N | Dual-mode cell outputs |
| plain_q | output | N | Flip-flop-only cell outputs |

## Verification
Set/reset and clock enable can both be high at the same clock edge. The bench raises both together with data sources that differ from the configured values, and expects the configured values in every cell. Set/reset can also change in the middle of a clock phase. The bench raises it halfway through a phase and drops it before the next edge. It then checks the synchronous build, which must ignore the pulse, against the asynchronous flip-flop and latch builds, which must settle on their configured values at once and keep them.

// File: rtl/srb_pkg.sv
package srb_pkg;
  typedef enum logic [1:0] {
    SRC_WIDE_FN = 2'd0,
    SRC_CARRY   = 2'd1,
    SRC_WMUX    = 2'd2,
    SRC_BYPASS  = 2'd3
  } dual_src_e;

  typedef enum logic {
    PSRC_NARROW = 1'b0,
    PSRC_BYPASS = 1'b1
  } plain_src_e;
endpackage

// File: rtl/srb_dsel.sv
module srb_dsel
  import srb_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [2*N-1:0] sel,
  input  logic [N-1:0]   wide_fn,
  input  logic [N-1:0]   carry,
  input  logic [N-1:0]   wmux,
  input  logic [N-1:0]   byp,
  output logic [N-1:0]   d
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    always_comb begin
      unique case (dual_src_e'(sel[2*i +: 2]))
        SRC_WIDE_FN: d[i] = wide_fn[i];
        SRC_CARRY:   d[i] = carry[i];
        SRC_WMUX:    d[i] = wmux[i];
        default:     d[i] = byp[i];
      endcase
    end
  end
endmodule

// File: rtl/srb_cell.sv
module srb_cell #(
  parameter bit LATCH = 1'b0,
  parameter bit ASYNC = 1'b0,
  parameter bit INIT  = 1'b0
) (
  input  logic gclk,
  input  logic ce,
  input  logic sr,
  input  logic d,
  output logic q
);
  logic q_r = INIT;

  if (LATCH && ASYNC) begin : g_lat_async
    always_latch begin
      if (sr)              q_r <= INIT;
      else if (gclk && ce) q_r <= d;
    end
  end else if (LATCH) begin : g_lat_sync
    always_latch begin
      if (gclk && (sr || ce)) q_r <= sr ? INIT : d;
    end
  end else if (ASYNC) begin : g_ff_async
    always_ff @(posedge gclk or posedge sr) begin
      if (sr)      q_r <= INIT;
      else if (ce) q_r <= d;
    end
  end else begin : g_ff_sync
    always_ff @(posedge gclk) begin
      if (sr)      q_r <= INIT;
      else if (ce) q_r <= d;
    end
  end

  assign q = q_r;
endmodule

// File: rtl/shared_ctl_regbank.sv
module shared_ctl_regbank
  import srb_pkg::*;
#(
  parameter int unsigned   N          = 4,
  parameter bit            DUAL_LATCH = 1'b0,
  parameter bit            SR_ASYNC   = 1'b0,
  parameter bit            CLK_INV    = 1'b0,
  parameter logic [N-1:0]  INIT_DUAL  = '0,
  parameter logic [N-1:0]  INIT_PLAIN = '0
) (
  input  logic           clk,
  input  logic           ce,
  input  logic           sr,
  input  logic [2*N-1:0] dual_sel,
  input  logic [N-1:0]   plain_sel,
  input  logic [N-1:0]   lut6_d,
  input  logic [N-1:0]   carry_d,
  input  logic [N-1:0]   wmux_d,
  input  logic [N-1:0]   lut5_d,
  input  logic [N-1:0]   byp_d,
  output logic [N-1:0]   dual_q,
  output logic [N-1:0]   plain_q
);
  logic         gclk;
  logic [N-1:0] dual_d;

  assign gclk = CLK_INV ? ~clk : clk;

  srb_dsel #(.N(N)) u_dsel (
    .sel     (dual_sel),
    .wide_fn (lut6_d),
    .carry   (carry_d),
    .wmux    (wmux_d),
    .byp     (byp_d),
    .d       (dual_d)
  );

  for (genvar i = 0; i < N; i++) begin : g_dual
    srb_cell #(.LATCH(DUAL_LATCH), .ASYNC(SR_ASYNC), .INIT(INIT_DUAL[i])) u_cell (
      .gclk (gclk),
      .ce   (ce),
      .sr   (sr),
      .d    (dual_d[i]),
      .q    (dual_q[i])
    );
  end

  if (DUAL_LATCH) begin : g_plain_off
    assign plain_q = INIT_PLAIN;
  end else begin : g_plain_on
    for (genvar i = 0; i < N; i++) begin : g_plain
      logic pd;
      assign pd = (plain_src_e'(plain_sel[i]) == PSRC_BYPASS) ? byp_d[i] : lut5_d[i];
      srb_cell #(.LATCH(1'b0), .ASYNC(SR_ASYNC), .INIT(INIT_PLAIN[i])) u_cell (
        .gclk (gclk),
        .ce   (ce),
        .sr   (sr),
        .d    (pd),
        .q    (plain_q[i])
      );
    end
  end
endmodule

// File: rtl/shared_ctl_regbank_chk.sv
module shared_ctl_regbank_chk #(
  parameter int unsigned  N          = 4,
  parameter bit           DUAL_LATCH = 1'b0,
  parameter bit           SR_ASYNC   = 1'b0,
  parameter bit           CLK_INV    = 1'b0,
  parameter logic [N-1:0] INIT_DUAL  = '0,
  parameter logic [N-1:0] INIT_PLAIN = '0
) (
  input logic           clk,
  input logic           ce,
  input logic           sr,
  input logic [2*N-1:0] dual_sel,
  input logic [N-1:0]   plain_sel,
  input logic [N-1:0]   byp_d,
  input logic [N-1:0]   dual_q,
  input logic [N-1:0]   plain_q
);
  logic gclk;
  logic armed = 1'b0;

  assign gclk = clk ^ CLK_INV;

  always_ff @(posedge gclk) armed <= 1'b1;

  if (!DUAL_LATCH) begin : g_edge_checks
    // R5
    sr_load_dual_chk: assert property (@(posedge gclk) disable iff (!armed)
      sr |=> dual_q == INIT_DUAL);

    // R5
    sr_load_plain_chk: assert property (@(posedge gclk) disable iff (!armed)
      sr |=> plain_q == INIT_PLAIN);

    if (!SR_ASYNC) begin : g_sync_checks
      // R4
      hold_dual_chk: assert property (@(posedge gclk) disable iff (!armed)
        (!sr && !ce) |=> $stable(dual_q) && $stable(plain_q));

      // R2
      byp_dual_chk: assert property (@(posedge gclk) disable iff (!armed)
        (ce && !sr && dual_sel == '1) |=> dual_q == $past(byp_d));

      // R3
      byp_plain_chk: assert property (@(posedge gclk) disable iff (!armed)
        (ce && !sr && plain_sel == '1) |=> plain_q == $past(byp_d));
    end
  end
endmodule

bind shared_ctl_regbank shared_ctl_regbank_chk #(
  .N(N), .DUAL_LATCH(DUAL_LATCH), .SR_ASYNC(SR_ASYNC), .CLK_INV(CLK_INV),
  .INIT_DUAL(INIT_DUAL), .INIT_PLAIN(INIT_PLAIN)
) u_chk (
  .clk(clk), .ce(ce), .sr(sr), .dual_sel(dual_sel), .plain_sel(plain_sel),
  .byp_d(byp_d), .dual_q(dual_q), .plain_q(plain_q)
);

// File: tb/shared_ctl_regbank_test.sv
module shared_ctl_regbank_test;
  localparam int CLK_P = 10;
  localparam logic [3:0] ID_S = 4'b1010, IP_S = 4'b0110;
  localparam logic [3:0] ID_A = 4'b0011, IP_A = 4'b1001;
  localparam logic [3:0] ID_L = 4'b0101, IP_L = 4'b1100;

  logic clk = 1'b0;
  logic ce = 1'b0, sr = 1'b0;
  logic [7:0] dual_sel = '0;
  logic [3:0] plain_sel = '0, lut6_d = '0, carry_d = '0, wmux_d = '0, lut5_d = '0, byp_d = '0;
  logic [3:0] dq_s, pq_s, dq_a, pq_a, dq_l, pq_l;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  shared_ctl_regbank #(.N(4), .DUAL_LATCH(0), .SR_ASYNC(0), .CLK_INV(0),
    .INIT_DUAL(ID_S), .INIT_PLAIN(IP_S)) uut (
    .clk, .ce, .sr, .dual_sel, .plain_sel, .lut6_d, .carry_d, .wmux_d,
    .lut5_d, .byp_d, .dual_q(dq_s), .plain_q(pq_s));

  shared_ctl_regbank #(.N(4), .DUAL_LATCH(0), .SR_ASYNC(1), .CLK_INV(1),
    .INIT_DUAL(ID_A), .INIT_PLAIN(IP_A)) uut_ai (
    .clk, .ce, .sr, .dual_sel, .plain_sel, .lut6_d, .carry_d, .wmux_d,
    .lut5_d, .byp_d, .dual_q(dq_a), .plain_q(pq_a));

  shared_ctl_regbank #(.N(4), .DUAL_LATCH(1), .SR_ASYNC(1), .CLK_INV(0),
    .INIT_DUAL(ID_L), .INIT_PLAIN(IP_L)) uut_lt (
    .clk, .ce, .sr, .dual_sel, .plain_sel, .lut6_d, .carry_d, .wmux_d,
    .lut5_d, .byp_d, .dual_q(dq_l), .plain_q(pq_l));

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_P * 20000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    // R1: configured values before any edge
    chk("R1 uut dual", dq_s, ID_S);   chk("R1 uut plain", pq_s, IP_S);
    chk("R1 ai dual", dq_a, ID_A);    chk("R1 ai plain", pq_a, IP_A);
    chk("R1 lt dual", dq_l, ID_L);    chk("R9 lt plain", pq_l, IP_L);

    // R2 R3: every uniform source code against every data pattern
    step();
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 16; p++) begin
        logic [3:0] pv;
        pv = 4'(p);
        ce = 1'b1; sr = 1'b0;
        dual_sel = {4{2'(s)}};
        lut6_d  = (s == 0) ? pv : ~pv;
        carry_d = (s == 1) ? pv : ~pv;
        wmux_d  = (s == 2) ? pv : ~pv;
        byp_d   = (s == 3) ? pv : ~pv;
        plain_sel = (s == 3) ? 4'hF : 4'h0;
        lut5_d  = (s == 3) ? ~pv : pv;
        step();
        chk("R2 uut dual", dq_s, pv);
        chk("R7 ai dual", dq_a, pv);
        chk("R8 lt dual", dq_l, pv);
        chk("R3 uut plain", pq_s, pv);
        chk("R3 ai plain", pq_a, pv);
        chk("R9 lt plain", pq_l, IP_L);
      end
    end

    // R4: enable low, sources change, outputs hold 1111
    ce = 1'b0; lut6_d = '0; carry_d = '0; wmux_d = '0; byp_d = '0; lut5_d = '0;
    step();
    chk("R4 uut dual", dq_s, 4'hF); chk("R4 uut plain", pq_s, 4'hF);
    chk("R4 ai dual", dq_a, 4'hF);  chk("R8 lt hold ce0", dq_l, 4'hF);

    // R2 R3: mixed per-cell selection
    ce = 1'b1;
    dual_sel = {2'd3, 2'd2, 2'd1, 2'd0};
    lut6_d = 4'b0001; carry_d = 4'b1100; wmux_d = 4'b0100; byp_d = 4'b1000;
    plain_sel = 4'b0101; lut5_d = 4'b0011;
    step();
    chk("R2 mixed dual", dq_s, 4'b1101); chk("R3 mixed plain", pq_s, 4'b0010);
    lut6_d = ~lut6_d; carry_d = ~carry_d; wmux_d = ~wmux_d; byp_d = 4'b0111;
    lut5_d = 4'b1100;
    step();
    chk("R2 mixed dual inv", dq_s, 4'b0010); chk("R3 mixed plain inv", pq_s, 4'b1101);

    // R8 R7: latch open while clk high, closes at fall; inverted FF takes fall
    dual_sel = '1; byp_d = 4'b0110;
    #1;
    chk("R8 lt transparent", dq_l, 4'b0110);
    chk("R2 uut before edge", dq_s, 4'b0010);
    #5;  // clk low now, falling edge passed
    chk("R7 ai at fall", dq_a, 4'b0110);
    byp_d = 4'b1001;
    #1;
    chk("R8 lt closed", dq_l, 4'b0110);
    chk("R7 ai holds", dq_a, 4'b0110);
    step();
    chk("R2 uut at rise", dq_s, 4'b1001);
    chk("R8 lt reopened", dq_l, 4'b1001);

    // R5: sr and ce together, sr wins
    byp_d = 4'b1111; lut5_d = 4'b1111; plain_sel = '0; sr = 1'b1;
    step();
    chk("R5 uut dual", dq_s, ID_S); chk("R5 uut plain", pq_s, IP_S);
    chk("R5 ai dual", dq_a, ID_A);  chk("R5 ai plain", pq_a, IP_A);
    chk("R5 lt dual", dq_l, ID_L);  chk("R9 lt plain sr", pq_l, IP_L);

    // R6: load all ones, then a mid-phase sr pulse
    sr = 1'b0;
    step();
    chk("R6 preload uut", dq_s, 4'hF);
    ce = 1'b0; sr = 1'b1;
    #1;
    chk("R6 sync waits", dq_s, 4'hF); chk("R6 sync waits plain", pq_s, 4'hF);
    chk("R6 async now", dq_a, ID_A);  chk("R6 async now plain", pq_a, IP_A);
    chk("R10 lt async", dq_l, ID_L);
    sr = 1'b0;
    step();
    chk("R6 sync missed pulse", dq_s, 4'hF);
    chk("R6 async kept", dq_a, ID_A);

    // R10: latch closed (clk low), sr forces configured value
    ce = 1'b1;
    step();
    chk("R8 lt reload", dq_l, 4'hF);
    ce = 1'b0;
    #5;
    sr = 1'b1;
    #1;
    chk("R10 lt closed sr", dq_l, ID_L);
    chk("R9 lt plain", pq_l, IP_L);
    sr = 1'b0;
    step();
    chk("R4 lt stays", dq_l, ID_L);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule